// File: doc/BRIEF.md
# Character I/O and Interrupt Controller

This block gives a small accumulator processor one character input channel and one character output channel, each with an 8-bit buffer and a ready flag. Characters arrive from and leave for an external device over valid/ready streams. The processor reaches the buffers and flags through I/O instructions. The sequencer presents six select bits from the instruction together with an execute strobe, and the block answers with an accumulator load strobe, the input character, or a skip indication.

The block also holds the interrupt enable and the interrupt request flip-flop. With interrupts enabled and either flag raised, the request is latched, but never while the sequencer is fetching. When the sequencer signals the end of an execute phase with a request pending, the block runs a three-step interrupt cycle. The cycle saves the program counter at address 0, sets it to 1, turns interrupts off and clears the sequencer's step counter.

Back-pressure rules: an input character is accepted on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low whenever the input buffer is full. `out_valid` stays high, with `out_data` held constant, until the device raises `out_ready`.

Top module: `io_intc`

## Requirements
- R1: After reset the input flag is 0 (`in_ready`=1), the output flag is 1 (`out_valid`=0), interrupt enable and request are 0, no interrupt cycle is active, and all strobes are 0.
- R2: On a cycle with `in_valid` and `in_ready` high, the character is stored and the input flag is set from the next cycle. While the flag is set, `in_ready` is 0 and incoming data is ignored.
- R3: An executed instruction with `io_sel[5]` raises `acc_load` in the same cycle, with `acc_char` equal to the stored input character, and clears the input flag from the next cycle. If a device transfer is accepted in the same cycle, the flag is set instead.
- R4: An executed instruction with `io_sel[4]` stores `ac_low` and clears the output flag, so `out_valid`=1 and `out_data` holds that character from the next cycle. A handshake sets the flag again. If a write and a handshake fall in the same cycle, the new character stays pending.
- R5: `skip` is high in the same cycle as an executed instruction whose `io_sel[3]` is set with the input flag at 1, or whose `io_sel[2]` is set with the output flag at 1.
- R6: An executed `io_sel[1]` sets interrupt enable from the next cycle and `io_sel[0]` clears it. When both are set, the result is cleared.
- R7: The request `irq_pending` becomes 1 in the cycle after one in which enable is 1, either flag is 1, `in_fetch` is 0 and no interrupt cycle is active. Otherwise it holds its value.
- R8: `cycle_end` with the request at 1 starts the interrupt cycle, and `icyc_active` is high for the next three cycles. `cycle_end` with the request at 0 has no effect.
- R9: In the first step `pc_in` is captured. In the second, `mem_we` and `pc_clr` are high, with `mem_addr`=0 and `mem_wdata` equal to the captured PC zero-extended. In the third, `pc_inc` and `sc_clr` are high. Afterwards enable and request are 0.
- R10: While the interrupt cycle is active, `io_exec` is ignored: no load, skip, buffer, flag or enable change.
- R11: While the interrupt cycle is active, `cycle_end` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Device offers an input character |
| in_data | input | 8 | Input character from the device |
| in_ready | output | 1 | Input buffer empty, can accept |
| out_valid | output | 1 | Output character pending for the device |
| out_data | output | 8 | Output character |
| out_ready | input | 1 | Device takes the output character |
| io_exec | input | 1 | Execute strobe of an I/O instruction |
| io_sel | input | 6 | Operation select bits of the instruction |
| ac_low | input | 8 | Low byte of the accumulator |
| acc_load | output | 1 | Load accumulator low byte from `acc_char` |
| acc_char | output | 8 | Stored input character |
| skip | output | 1 | Skip the next instruction |
| in_fetch | input | 1 | Sequencer is in a fetch step |
| cycle_end | input | 1 | Execute phase ends this cycle |
| pc_in | input | 12 | Current program counter |
| irq_pending | output | 1 | Interrupt request flip-flop |
| ien | output | 1 | Interrupt enable |
| icyc_active | output | 1 | Interrupt cycle in progress |
| mem_we | output | 1 | Write the saved PC to memory |
| mem_addr | output | 12 | Store address (always 0) |
| mem_wdata | output | 16 | Saved PC, zero-extended |
| pc_clr | output | 1 | Clear program counter |
| pc_inc | output | 1 | Increment program counter |
| sc_clr | output | 1 | Clear sequencer step counter |

## Verification
Two functions can fall on the same flag in one cycle: a device transfer and a processor instruction. One case is an accepted input character while an input-take instruction runs. The other is an output handshake while an output-write instruction runs. Enable and disable in one instruction, and instructions or `cycle_end` issued during the interrupt cycle, are further coincidences. Directed sequences schedule these coincidences on exact cycles, and a random phase drives all inputs freely. A behavioural reference model judges every output on every clock.

// File: rtl/io_intc_pkg.sv
package io_intc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RT0, ST_RT1, ST_RT2} icyc_t;
  localparam int OP_N    = 6;
  localparam int OP_TAKE = 5;
  localparam int OP_PUT  = 4;
  localparam int OP_SKI  = 3;
  localparam int OP_SKO  = 2;
  localparam int OP_ION  = 1;
  localparam int OP_IOF  = 0;
endpackage

// File: rtl/io_in_chan.sv
module io_in_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dv_valid,
  input  logic [CHAR_W-1:0] dv_data,
  output logic              dv_ready,
  input  logic              take,
  output logic              flag,
  output logic [CHAR_W-1:0] char_q
);
  logic accept;
  assign dv_ready = ~flag;
  assign accept   = dv_valid & dv_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      char_q <= '0;
    end else if (accept) begin
      flag   <= 1'b1;
      char_q <= dv_data;
    end else if (take) begin
      flag   <= 1'b0;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_valid && dv_ready) |=> (flag && char_q == $past(dv_data)));
  p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && flag) |=> !flag);
endmodule

// File: rtl/io_out_chan.sv
module io_out_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [CHAR_W-1:0] put_data,
  output logic              dv_valid,
  input  logic              dv_ready,
  output logic [CHAR_W-1:0] dv_data,
  output logic              flag
);
  assign dv_valid = ~flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= 1'b1;
      dv_data <= '0;
    end else if (put) begin
      flag    <= 1'b0;
      dv_data <= put_data;
    end else if (dv_valid && dv_ready) begin
      flag    <= 1'b1;
    end
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_valid && !dv_ready && !put) |=> (dv_valid && $stable(dv_data)));
  p_put_r4: assert property (@(posedge clk) disable iff (!rst_n)
    put |=> (dv_valid && dv_data == $past(put_data)));
endmodule

// File: rtl/io_irq_seq.sv
module io_irq_seq
  import io_intc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_in,
  input  logic              flag_out,
  input  logic              in_fetch,
  input  logic              cycle_end,
  input  logic              ion,
  input  logic              iof,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              ien,
  output logic              req,
  output logic              active,
  output logic [ADDR_W-1:0] tr_q,
  output logic              mem_we,
  output logic              pc_clr,
  output logic              pc_inc,
  output logic              sc_clr
);
  icyc_t state;

  assign active = (state != ST_IDLE);
  assign mem_we = (state == ST_RT1);
  assign pc_clr = (state == ST_RT1);
  assign pc_inc = (state == ST_RT2);
  assign sc_clr = (state == ST_RT2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tr_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cycle_end && req) state <= ST_RT0;
        ST_RT0: begin
          tr_q  <= pc_in;
          state <= ST_RT1;
        end
        ST_RT1:  state <= ST_RT2;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien <= 1'b0;
      req <= 1'b0;
    end else begin
      if (state == ST_RT2)  ien <= 1'b0;
      else if (iof)         ien <= 1'b0;
      else if (ion)         ien <= 1'b1;

      if (state == ST_RT2) req <= 1'b0;
      else if (state == ST_IDLE && ien && (flag_in || flag_out) && !in_fetch)
        req <= 1'b1;
    end
  end

  p_rset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(ien && (flag_in || flag_out) && !in_fetch));
  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && req && !active) |=> active);
  p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (pc_inc && sc_clr));
  p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> (!ien && !req && !active));
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, pc_inc}));
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pc_inc) |=> active);
endmodule

// File: rtl/io_intc.sv
module io_intc
  import io_intc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready,
  input  logic              io_exec,
  input  logic [OP_N-1:0]   io_sel,
  input  logic [CHAR_W-1:0] ac_low,
  output logic              acc_load,
  output logic [CHAR_W-1:0] acc_char,
  output logic              skip,
  input  logic              in_fetch,
  input  logic              cycle_end,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              irq_pending,
  output logic              ien,
  output logic              icyc_active,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              pc_clr,
  output logic              pc_inc,
  output logic              sc_clr
);
  localparam int PAD_W = WORD_W - ADDR_W;

  logic [OP_N-1:0]   op_hit;
  logic              exec_ok;
  logic              fgi, fgo;
  logic [ADDR_W-1:0] tr_q;

  assign exec_ok = io_exec & ~icyc_active;

  for (genvar i = 0; i < OP_N; i++) begin : g_dec
    assign op_hit[i] = exec_ok & io_sel[i];
  end

  io_in_chan #(.CHAR_W(CHAR_W)) u_in (
    .clk(clk), .rst_n(rst_n), .dv_valid(in_valid), .dv_data(in_data),
    .dv_ready(in_ready), .take(op_hit[OP_TAKE]), .flag(fgi), .char_q(acc_char)
  );

  io_out_chan #(.CHAR_W(CHAR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .put(op_hit[OP_PUT]), .put_data(ac_low),
    .dv_valid(out_valid), .dv_ready(out_ready), .dv_data(out_data), .flag(fgo)
  );

  io_irq_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .flag_in(fgi), .flag_out(fgo),
    .in_fetch(in_fetch), .cycle_end(cycle_end),
    .ion(op_hit[OP_ION]), .iof(op_hit[OP_IOF]), .pc_in(pc_in),
    .ien(ien), .req(irq_pending), .active(icyc_active), .tr_q(tr_q),
    .mem_we(mem_we), .pc_clr(pc_clr), .pc_inc(pc_inc), .sc_clr(sc_clr)
  );

  assign acc_load  = op_hit[OP_TAKE];
  assign skip      = (op_hit[OP_SKI] & fgi) | (op_hit[OP_SKO] & fgo);
  assign mem_addr  = '0;
  assign mem_wdata = {{PAD_W{1'b0}}, tr_q};

  p_iof_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok && io_sel[OP_ION] && io_sel[OP_IOF]) |=> !ien);
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_exec && icyc_active) |-> (!acc_load && !skip));
  p_noflag_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && !io_sel[OP_SKO]) |-> !in_ready);
endmodule

// File: tb/io_intc_test.sv
module io_intc_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, out_ready = 0, io_exec = 0, in_fetch = 0, cycle_end = 0;
  logic [7:0] in_data = 0, ac_low = 0;
  logic [5:0] io_sel = 0;
  logic [11:0] pc_in = 0;
  logic in_ready, out_valid, acc_load, skip, irq_pending, ien, icyc_active;
  logic mem_we, pc_clr, pc_inc, sc_clr;
  logic [7:0] out_data, acc_char;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit m_fgi, m_fgo, m_ien, m_r;
  int m_step;
  logic [7:0] m_inpr, m_outr;
  logic [11:0] m_tr;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_intc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .io_exec(io_exec), .io_sel(io_sel), .ac_low(ac_low),
    .acc_load(acc_load), .acc_char(acc_char), .skip(skip), .in_fetch(in_fetch),
    .cycle_end(cycle_end), .pc_in(pc_in), .irq_pending(irq_pending), .ien(ien),
    .icyc_active(icyc_active), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_clr(pc_clr), .pc_inc(pc_inc), .sc_clr(sc_clr)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit ok;
    ok = io_exec && (m_step == 0);
    chk("R2", "in_ready", in_ready, !m_fgi);
    chk("R4", "out_valid", out_valid, !m_fgo);
    chk("R4", "out_data", out_data, m_outr);
    chk("R3", "acc_load", acc_load, ok && io_sel[5]);
    chk("R3", "acc_char", acc_char, m_inpr);
    chk("R5", "skip", skip, ok && ((io_sel[3] && m_fgi) || (io_sel[2] && m_fgo)));
    chk("R6", "ien", ien, m_ien);
    chk("R7", "irq_pending", irq_pending, m_r);
    chk("R8", "icyc_active", icyc_active, m_step != 0);
    chk("R9", "mem_we", mem_we, m_step == 2);
    chk("R9", "pc_clr", pc_clr, m_step == 2);
    chk("R9", "mem_addr", mem_addr, 0);
    chk("R9", "mem_wdata", mem_wdata, {4'h0, m_tr});
    chk("R9", "pc_inc", pc_inc, m_step == 3);
    chk("R9", "sc_clr", sc_clr, m_step == 3);
  endtask

  task automatic model_step();
    bit ok, acc, wr, done_o, nfgi, nfgo, nien, nr;
    int nstep;
    ok = io_exec && (m_step == 0);   // R10: instructions ignored in interrupt cycle
    acc = in_valid && !m_fgi;
    wr = ok && io_sel[4];
    done_o = !m_fgo && out_ready;
    nfgi = acc ? 1'b1 : ((ok && io_sel[5]) ? 1'b0 : m_fgi);
    nfgo = wr ? 1'b0 : (done_o ? 1'b1 : m_fgo);
    nien = m_ien;
    if (m_step == 3) nien = 0;
    else if (ok && io_sel[0]) nien = 0;
    else if (ok && io_sel[1]) nien = 1;
    nr = m_r;
    if (m_step == 3) nr = 0;
    else if (m_step == 0 && m_ien && (m_fgi || m_fgo) && !in_fetch) nr = 1;
    // R11: cycle_end only acts from idle
    case (m_step)
      0: nstep = (cycle_end && m_r) ? 1 : 0;
      1: begin nstep = 2; m_tr = pc_in; end
      2: nstep = 3;
      default: nstep = 0;
    endcase
    if (acc) m_inpr = in_data;
    if (wr) m_outr = ac_low;
    m_fgi = nfgi; m_fgo = nfgo; m_ien = nien; m_r = nr; m_step = nstep;
  endtask

  task automatic tick();
    #1;
    compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_in();
    in_valid = 0; out_ready = 0; io_exec = 0; io_sel = 0;
    in_fetch = 1; cycle_end = 0;
  endtask

  task automatic op(logic [5:0] s);
    io_exec = 1; io_sel = s;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_fgi = 0; m_fgo = 1; m_ien = 0; m_r = 0; m_step = 0;
    m_inpr = 0; m_outr = 0; m_tr = 0;
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "ien/irq/active", {ien, irq_pending, icyc_active}, 0);
    chk("R1", "strobes", {mem_we, pc_clr, pc_inc, sc_clr, acc_load, skip}, 0);
    @(negedge clk);

    // R2 input accept, then ignored while full
    in_valid = 1; in_data = 8'h41; tick();
    in_data = 8'h55; tick();
    chk("R2", "held char", acc_char, 8'h41);
    in_valid = 0;
    op(6'b001000); tick();             // R5 skip on input flag
    op(6'b000100); tick();             // R5 skip on output flag
    op(6'b100000); tick();             // R3 take
    idle_in(); tick();
    chk("R3", "flag cleared", in_ready, 1);

    // R3 collision: take with empty buffer and device transfer together
    in_valid = 1; in_data = 8'h7E; op(6'b100000); tick();
    idle_in(); tick();
    chk("R3", "set wins", in_ready, 0);
    op(6'b100000); tick(); idle_in();

    // R4 output with back-pressure
    ac_low = 8'h5A; op(6'b010000); tick(); idle_in();
    repeat (3) tick();
    // R4 collision: handshake and new write in one cycle
    out_ready = 1; ac_low = 8'hC3; op(6'b010000); tick(); io_exec = 0; io_sel = 0;
    out_ready = 0; tick();
    chk("R4", "new char pending", {out_valid, out_data}, {1'b1, 8'hC3});
    out_ready = 1; tick(); idle_in(); tick();

    // R6 enable/disable, both -> disabled
    op(6'b000010); tick();
    op(6'b000011); in_fetch = 1; tick(); idle_in(); tick();
    chk("R6", "both clears", ien, 0);

    // R7 request blocked during fetch, then set
    op(6'b000010); tick(); idle_in();
    repeat (3) tick();
    chk("R7", "no request in fetch", irq_pending, 0);
    in_fetch = 0; tick();
    chk("R7", "request set", irq_pending, 1);
    // R8 start, R10/R11 stimulus during cycle
    pc_in = 12'h123; cycle_end = 1; tick();
    cycle_end = 1; op(6'b100011); in_valid = 0; tick();
    pc_in = 12'h456; tick(); tick();
    idle_in(); tick();
    chk("R9", "after cycle ien/irq", {ien, irq_pending}, 0);
    chk("R9", "saved pc", mem_wdata, 16'h0123);
    // R8 cycle_end without request
    cycle_end = 1; in_fetch = 0; tick(); idle_in(); tick();
    chk("R8", "no start", icyc_active, 0);

    // random phase over all requirements
    for (int i = 0; i < 3000; i++) begin
      in_valid = $urandom_range(0, 1);
      in_data = 8'($urandom);
      out_ready = ($urandom_range(0, 3) == 0);
      io_exec = ($urandom_range(0, 2) == 0);
      io_sel = 6'($urandom);
      ac_low = 8'($urandom);
      in_fetch = ($urandom_range(0, 2) == 0);
      cycle_end = ($urandom_range(0, 3) == 0);
      pc_in = 12'($urandom);
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule